// File: doc/BRIEF.md
# Byte-Addressed Load/Store Memory Unit

This block is a data memory that accepts byte addresses but keeps its contents in 32-bit words. Every command arrives as one token that carries an operation code, a byte address and a data word. The address has already been formed upstream from a base value and a signed offset. Sub-word loads pick the addressed byte or halfword out of the stored word. They then extend the value with its sign or with zeros, as the code asks. Sub-word stores update only the addressed bytes and leave the rest of the word unchanged.

The unit handles one command at a time. A load, or a load-upper-immediate, returns one data token on the response port. A store returns one completion token on the done port once the write has landed in the array. Both output ports hold their token until the consumer accepts it. Halfword and word accesses that are not aligned are aligned by dropping the low address bits. Byte order is little-endian.

Top module: `bytemem_unit`

## Requirements
- R1: After reset every byte of the array reads as zero, `cmd_ready` is high, and neither `rsp_valid` nor `done_valid` is asserted.
- R2: Byte address A refers to bits [8*(A mod 4)+7 : 8*(A mod 4)] of word A div 4 (little-endian).
- R3: Op code 0 loads a byte and sign-extends it to 32 bits. Op code 1 loads a byte and zero-extends it.
- R4: Op code 2 loads a halfword and sign-extends it. Op code 3 loads a halfword and zero-extends it. Address bit 1 selects the upper half (bits 31:16) and address bit 0 is ignored.
- R5: Op code 4 loads the whole word and ignores address bits [1:0].
- R6: Op code 5 returns `cmd_wdata[15:0]` in bits 31:16 with zeros in bits 15:0. It ignores the address and leaves the array unchanged.
- R7: Op code 6 writes `cmd_wdata[7:0]` into the addressed byte only.
- R8: Op code 7 writes `cmd_wdata[15:0]` into the two bytes of the addressed halfword only. Address bit 0 is ignored.
- R9: Op code 8 writes all of `cmd_wdata` into the addressed word and ignores address bits [1:0].
- R10: Each store yields exactly one done token and no data token. Each load (codes 0 to 5) yields exactly one data token and no done token.
- R11: `cmd_ready` is high only while idle. A token appears on the second clock edge after the accepting edge. A token stays valid, with its data stable, until it is accepted.
- R12: Op codes 9 to 15 behave exactly as a word load (code 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command token offered |
| cmd_ready | output | 1 | Unit idle, command accepted on this edge |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | ADDR_W | Effective byte address |
| cmd_wdata | input | 32 | Store data or immediate |
| rsp_valid | output | 1 | Load result token valid |
| rsp_ready | input | 1 | Consumer takes the load result |
| rsp_data | output | 32 | Extended load result |
| done_valid | output | 1 | Store completion token valid |
| done_ready | input | 1 | Consumer takes the completion token |

## Verification
The hardest case to reach is a partial store that must leave its neighbouring bytes untouched. This is only visible once those neighbours hold distinct, nonzero values with their top bits set. The bench therefore first fills every byte of a small array with a different pattern through byte stores. It then overwrites halfwords and words at every byte offset, including misaligned ones. After each write it reads back the whole containing word and compares it with an arithmetic shadow of the byte array. Sign extension is exercised by ensuring the pattern places values both above and below the sign boundary in every lane.

// File: rtl/bytemem_pkg.sv
`timescale 1ns/1ps
package bytemem_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [3:0] {
    OP_LB  = 4'd0,
    OP_LBU = 4'd1,
    OP_LH  = 4'd2,
    OP_LHU = 4'd3,
    OP_LW  = 4'd4,
    OP_LUI = 4'd5,
    OP_SB  = 4'd6,
    OP_SH  = 4'd7,
    OP_SW  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_LOAD_RSP,
    ST_STORE_RSP
  } state_e;

  // Codes outside the defined set fall back to a word load.
  function automatic op_e decode_op(input logic [3:0] code);
    if (code <= 4'd8) return op_e'(code);
    return OP_LW;
  endfunction

  function automatic logic is_store(input op_e op);
    return (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
  endfunction

  // Lanes touched by a store at the given low address bits.
  function automatic logic [LANES-1:0] lane_enables(input op_e op, input logic [1:0] lo);
    logic [LANES-1:0] be;
    be = '0;
    case (op)
      OP_SB:   be = 4'b0001 << lo;
      OP_SH:   be = lo[1] ? 4'b1100 : 4'b0011;
      OP_SW:   be = 4'b1111;
      default: be = '0;
    endcase
    return be;
  endfunction

  // Replicate the store data so that every possible lane sees it.
  function automatic logic [WORD_W-1:0] replicate_store(input op_e op, input logic [WORD_W-1:0] d);
    case (op)
      OP_SB:   return {4{d[7:0]}};
      OP_SH:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] extend_byte(input logic [7:0] b, input logic signed_ext);
    return {{24{signed_ext & b[7]}}, b};
  endfunction

  function automatic logic [WORD_W-1:0] extend_half(input logic [15:0] h, input logic signed_ext);
    return {{16{signed_ext & h[15]}}, h};
  endfunction

  // Pick and extend the addressed part of a stored word.
  function automatic logic [WORD_W-1:0] shape_load(input op_e op, input logic [1:0] lo,
                                                   input logic [WORD_W-1:0] word,
                                                   input logic [15:0] imm);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    sel_b = word[8*lo +: 8];
    sel_h = lo[1] ? word[31:16] : word[15:0];
    case (op)
      OP_LB:   return extend_byte(sel_b, 1'b1);
      OP_LBU:  return extend_byte(sel_b, 1'b0);
      OP_LH:   return extend_half(sel_h, 1'b1);
      OP_LHU:  return extend_half(sel_h, 1'b0);
      OP_LUI:  return {imm, 16'h0000};
      default: return word;
    endcase
  endfunction

endpackage

// File: rtl/bytemem_array.sv
`timescale 1ns/1ps
module bytemem_array
  import bytemem_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  byte_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);

  // One byte-wide bank per lane; each bank writes on its own enable.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= 8'h00;
      end else if (wr_en && byte_en[ln]) begin
        bank[idx] <= wr_word[8*ln +: 8];
      end
    end

    assign rd_word[8*ln +: 8] = bank[idx];
  end

endmodule

// File: rtl/bytemem_lane.sv
`timescale 1ns/1ps
module bytemem_lane
  import bytemem_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - 2
) (
  input  op_e               req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  word_idx,
  output logic [LANES-1:0]  byte_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] ld_result
);

  logic [1:0] lo;

  assign lo        = req_addr[1:0];
  assign word_idx  = req_addr[ADDR_W-1:2];
  assign byte_en   = lane_enables(req_op, lo);
  assign wr_word   = replicate_store(req_op, req_wdata);
  assign ld_result = shape_load(req_op, lo, rd_word, req_wdata[15:0]);

endmodule

// File: rtl/bytemem_ctrl.sv
`timescale 1ns/1ps
module bytemem_ctrl
  import bytemem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  input  logic              rsp_ready,
  input  logic              done_ready,
  input  logic [WORD_W-1:0] ld_result,
  output op_e               req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  output logic              exec_fire,
  output logic              exec_store,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              done_valid
);

  state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_op    <= OP_LB;
      req_addr  <= '0;
      req_wdata <= '0;
      rsp_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          req_op    <= decode_op(cmd_op);
          req_addr  <= cmd_addr;
          req_wdata <= cmd_wdata;
          state     <= ST_EXEC;
        end
        ST_EXEC: if (is_store(req_op)) begin
          state <= ST_STORE_RSP;
        end else begin
          rsp_data <= ld_result;
          state    <= ST_LOAD_RSP;
        end
        ST_LOAD_RSP:  if (rsp_ready)  state <= ST_IDLE;
        ST_STORE_RSP: if (done_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state == ST_IDLE);
  assign exec_fire  = (state == ST_EXEC);
  assign exec_store = exec_fire && is_store(req_op);
  assign rsp_valid  = (state == ST_LOAD_RSP);
  assign done_valid = (state == ST_STORE_RSP);

endmodule

// File: rtl/bytemem_unit.sv
`timescale 1ns/1ps
module bytemem_unit
  import bytemem_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              done_valid,
  input  logic              done_ready
);

  // Named internal events, exposed for the checker.
  op_e               req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] req_wdata;
  logic              exec_fire;
  logic              exec_store;
  logic [IDX_W-1:0]  word_idx;
  logic [LANES-1:0]  byte_en;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] ld_result;

  bytemem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .cmd_ready  (cmd_ready),
    .rsp_ready  (rsp_ready),
    .done_ready (done_ready),
    .ld_result  (ld_result),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .exec_fire  (exec_fire),
    .exec_store (exec_store),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .done_valid (done_valid)
  );

  bytemem_lane #(.ADDR_W(ADDR_W)) u_lane (
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_word   (rd_word),
    .word_idx  (word_idx),
    .byte_en   (byte_en),
    .wr_word   (wr_word),
    .ld_result (ld_result)
  );

  bytemem_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (exec_store),
    .byte_en (byte_en),
    .idx     (word_idx),
    .wr_word (wr_word),
    .rd_word (rd_word)
  );

endmodule

// File: rtl/bytemem_unit_chk.sv
`timescale 1ns/1ps
module bytemem_unit_chk
  import bytemem_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        done_valid,
  input logic        done_ready,
  input logic        exec_fire,
  input logic        exec_store,
  input op_e         req_op,
  input logic [3:0]  byte_en
);

  AST_TOKEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && done_valid)); // R10

  AST_STORE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_store |=> done_valid && !rsp_valid); // R10

  AST_LOAD_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire && !exec_store |=> rsp_valid && !done_valid); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R11

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire || rsp_valid || done_valid) |-> !cmd_ready); // R11

  AST_ACCEPT_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> exec_fire); // R11

  AST_SB_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_store && req_op == OP_SB |-> $countones(byte_en) == 1); // R7

  AST_SH_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    exec_store && req_op == OP_SH |-> (byte_en == 4'b0011 || byte_en == 4'b1100)); // R8

  AST_SW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    exec_store && req_op == OP_SW |-> byte_en == 4'b1111); // R9

endmodule

bind bytemem_unit bytemem_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .done_valid (done_valid),
  .done_ready (done_ready),
  .exec_fire  (exec_fire),
  .exec_store (exec_store),
  .req_op     (req_op),
  .byte_en    (byte_en)
);

// File: tb/bytemem_unit_bench.sv
`timescale 1ns/1ps
module bytemem_unit_bench;

  localparam int DEPTH  = 8;
  localparam int NBYTES = DEPTH * 4;
  localparam int ADDR_W = $clog2(DEPTH) + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [3:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [31:0]       cmd_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [31:0]       rsp_data;
  logic              done_valid;
  logic              done_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Shadow of the array, one entry per byte.
  int shadow [NBYTES];

  always #2 clk = ~clk;

  bytemem_unit #(.DEPTH(DEPTH)) u_bytemem_unit (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done_valid(done_valid), .done_ready(done_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int word_val(input int a);
    int base = a - (a % 4);
    return shadow[base] + 256 * shadow[base+1] + 65536 * shadow[base+2] + 16777216 * shadow[base+3];
  endfunction

  function automatic logic [31:0] expect_load(input int op, input int a, input logic [31:0] wd);
    int v;
    int hb;
    case (op)
      0: begin v = shadow[a]; if (v > 127) v = v - 256; return 32'(v); end
      1: return 32'(shadow[a]);
      2: begin hb = a - (a % 2); v = shadow[hb] + 256 * shadow[hb+1];
               if (v > 32767) v = v - 65536; return 32'(v); end
      3: begin hb = a - (a % 2); return 32'(shadow[hb] + 256 * shadow[hb+1]); end
      5: return 32'(int'(wd % 65536) * 65536);
      default: return 32'(word_val(a));
    endcase
  endfunction

  task automatic model_store(input int op, input int a, input logic [31:0] d);
    int base;
    int n;
    n = (op == 6) ? 1 : (op == 7) ? 2 : 4;
    base = a - (a % n);
    for (int i = 0; i < n; i++) shadow[base+i] = int'((d / (32'd1 << (8*i))) % 256);
  endtask

  // Send one command and collect its token; hold delays acceptance.
  task automatic issue(input int op, input int a, input logic [31:0] wd, input int hold,
                       input string req, output logic [31:0] rd, output bit was_store);
    logic [31:0] first;
    bit want_store;
    want_store = (op >= 6 && op <= 8);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_addr = ADDR_W'(a); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!rsp_valid && !done_valid && !cmd_ready, "R11 latency/busy",
          {30'd0, rsp_valid, done_valid}, 32'd0);
    @(negedge clk);
    check(want_store ? (done_valid && !rsp_valid) : (rsp_valid && !done_valid), req,
          {30'd0, rsp_valid, done_valid}, want_store ? 32'd1 : 32'd2);
    first = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check((rsp_valid || done_valid) && rsp_data == first && !cmd_ready, "R11 hold",
            rsp_data, first);
    end
    rd = rsp_data;
    was_store = done_valid;
    rsp_ready = 1'b1; done_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0; done_ready = 1'b0;
    check(!rsp_valid && !done_valid, "R10 single token", {30'd0, rsp_valid, done_valid}, 32'd0);
  endtask

  task automatic do_store(input int op, input int a, input logic [31:0] d, input string req);
    logic [31:0] rd;
    bit st;
    issue(op, a, d, 0, req, rd, st);
    model_store(op, a, d);
  endtask

  task automatic do_load(input int op, input int a, input logic [31:0] wd, input string req);
    logic [31:0] rd;
    bit st;
    logic [31:0] ex;
    issue(op, a, wd, 0, req, rd, st);
    ex = expect_load(op, a, wd);
    check(rd === ex, req, rd, ex);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    check(cmd_ready && !rsp_valid && !done_valid, "R1 idle after reset",
          {29'd0, cmd_ready, rsp_valid, done_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !rsp_valid && !done_valid, "R1 idle out of reset",
          {29'd0, cmd_ready, rsp_valid, done_valid}, 32'd4);
    for (int w = 0; w < DEPTH; w++) do_load(4, 4*w, 32'h0, "R1 zero contents");

    // R7 / R2: fill each byte individually with distinct values, both signs.
    for (int a = 0; a < NBYTES; a++) do_store(6, a, 32'hA5A5_A500 | 32'((a * 77 + 13) % 256), "R7 byte store");
    for (int w = 0; w < DEPTH; w++) do_load(4, 4*w, 32'h0, "R2 little-endian word");

    // R3 R4 R5: every load form at every byte address.
    for (int a = 0; a < NBYTES; a++) begin
      do_load(0, a, 32'h0, "R3 signed byte");
      do_load(1, a, 32'h0, "R3 unsigned byte");
      do_load(2, a, 32'h0, "R4 signed half");
      do_load(3, a, 32'h0, "R4 unsigned half");
      do_load(4, a, 32'h0, "R5 word");
    end

    // R8: halfword stores at every offset, then whole-word readback.
    for (int a = 0; a < NBYTES; a++) begin
      do_store(7, a, 32'h5A00_0000 | 32'(a * 4099 + 32768), "R8 half store");
      do_load(4, a, 32'h0, "R8 neighbours kept");
      do_load(2, a, 32'h0, "R8 half readback");
    end

    // R9: word stores at every offset.
    for (int a = 0; a < NBYTES; a++) begin
      do_store(8, a, 32'(a) * 32'h0101_0107 ^ 32'h8C3E_11F0, "R9 word store");
      do_load(4, a, 32'h0, "R9 word readback");
    end

    // R6: immediate placement; array left untouched.
    for (int k = 0; k < 8; k++) begin
      do_load(5, k * 3, 32'hDEAD_0000 | 32'(k * 8191 + 7), "R6 upper immediate");
      do_load(4, k * 4 % NBYTES, 32'h0, "R6 array unchanged");
    end

    // R12: unused codes behave as word loads.
    for (int c = 9; c < 16; c++) begin
      logic [31:0] rd;
      bit st;
      logic [31:0] ex;
      issue(c, (c * 5) % NBYTES, 32'h0, 0, "R12 unused code", rd, st);
      ex = expect_load(4, (c * 5) % NBYTES, 32'h0);
      check(rd === ex, "R12 unused code", rd, ex);
    end

    // R11: back-pressure on both output ports.
    begin
      logic [31:0] rd;
      bit st;
      issue(0, 5, 32'h0, 4, "R11 load held", rd, st);
      check(rd === expect_load(0, 5, 32'h0), "R11 load held data", rd, expect_load(0, 5, 32'h0));
      issue(6, 9, 32'h0000_0042, 3, "R10 store held", rd, st);
      check(st, "R10 done token", {31'd0, st}, 32'd1);
      model_store(6, 9, 32'h42);
      do_load(1, 9, 32'h0, "R7 held store committed");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule